// File: doc/BRIEF.md
# Mesh Node Ray Packet Dispatcher

This block is the packet-handling core of one node in a square mesh of ray-tracing nodes. Each node owns a rectangular slab of scene space and a 2^PIX_X_LOG2 by 2^PIX_Y_LOG2 tile of pixels. The block accepts packets on six input ports: four neighbours, a self loopback and a host. It picks one packet at a time and decides its fate. The block then issues between one and three outgoing packets, one per cycle, on six output ports: four neighbours, the self loopback (used for rays born inside the local volume) and the local accumulation port (used for returns that have reached home and for pixel clears).

For a ray packet, the block asks an external intersection unit for the result of the local ray–surface test. It presents the held ray on `isect_ray_o` and reads the answer in the same cycle. The answer consists of hit and surface flags, an exit-face code, light and shading intensities, new directions and the hit position. The block applies the split-counter rule and builds the outgoing list. It routes every return toward the node that owns its home pixel, moving along X first and then along Y. When no input is pending, the block launches one new ray for each local pixel, once each.

Top module: `mesh_ray_dispatch`

## Requirements
- R1: While rst_ni is low, no out_valid_o bit is set.
- R2: When no in_valid_i bit is set, the block launches its local pixels, once each, in index order. Pixel index i has local x = i mod 2^PIX_X_LOG2 and local y = i div 2^PIX_X_LOG2. Each launch emits two packets, in order. The first is a clear packet (kind 2) on the accumulation port. The second is a ray (kind 0) with zero direction, intensity, entry and counter on the self port. Both packets carry home x = NODE_X*2^PIX_X_LOG2 + local x and home y = NODE_Y*2^PIX_Y_LOG2 + local y.
- R3: A ray with isect_hit_i low and an exit code 0..3 is sent unchanged on the output port whose number equals the code. The codes are 0 = +y, 1 = +x, 2 = -y and 3 = -x.
- R4: A ray with isect_hit_i low and an exit code of 4 or more becomes a return (kind 1). The return keeps the ray's home and counter. Its intensity is isect_light_int_i when isect_light_i is high and zero otherwise. Its direction and entry fields are zero.
- R5: Every return, whether incoming or generated, is routed by its home node. The home node is home x >> PIX_X_LOG2 and home y >> PIX_Y_LOG2. If the home node x is above NODE_X the return goes to port 1, and if it is below NODE_X it goes to port 3. Otherwise, if the home node y is above NODE_Y it goes to port 0, and if it is below NODE_Y it goes to port 2. Otherwise it goes to the accumulation port 5. Incoming returns are forwarded unchanged.
- R6: On a hit with a diffuse surface, the first emission is a return carrying isect_diff_int_i. Its counter is the incoming counter plus one when two or more of the diffuse, specular and transparent flags are set, and the incoming counter otherwise.
- R7: When all three surface flags are set, the reflected and transmitted rays carry the incoming counter plus two. When exactly two flags are set, they carry the incoming counter plus one. When one flag is set, they carry the counter unchanged. The emission order is return, reflected ray, transmitted ray.
- R8: The reflected ray (from the specular flag) and the transmitted ray (from the transparent flag) leave on self port 4. Each takes its own direction and intensity from the intersection inputs, its entry from isect_hit_pos_i, and the home of the incoming ray. A hit with no surface flag emits a zero-intensity return with the counter unchanged.
- R9: Pending inputs are served round-robin. After port p is served, the search for the next port starts at port p+1 and wraps around. Port numbers are 0..3 for the neighbours, 4 for self and 5 for host.
- R10: While the current emission's port is not ready, that emission is held stable, no later emission is issued and no input is accepted.
- R11: At most one out_valid_o bit and at most one in_ready_o bit are set in any cycle, and in_ready_o is only set for a valid input.

The packet format, from MSB to LSB, is: kind (2 bits; 0 ray, 1 return, 2 clear), direction (24), intensity (24), home y (8), home x (8), entry (24), counter (8). Port p uses the bit slice [p*PKT_W +: PKT_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 6 | Input packet valid, one bit per input port |
| in_ready_o | output | 6 | Input packet accepted, one bit per input port |
| in_pkt_i | input | 6*PKT_W | Input packets, one slice per port |
| out_valid_o | output | 6 | Output packet valid, one bit per output port |
| out_ready_i | input | 6 | Output port can take a packet |
| out_pkt_o | output | 6*PKT_W | Output packets, one slice per port |
| isect_req_o | output | 1 | Held ray is being tested this cycle |
| isect_ray_o | output | PKT_W | Ray under test |
| isect_hit_i | input | 1 | Ray hits a surface in the local volume |
| isect_diffuse_i | input | 1 | Hit surface is diffuse |
| isect_specular_i | input | 1 | Hit surface reflects specularly |
| isect_transparent_i | input | 1 | Hit surface transmits |
| isect_exit_i | input | 3 | Exit face of a miss; 4 or more means the ray leaves the array |
| isect_light_i | input | 1 | Leaving ray points at a light |
| isect_light_int_i | input | 24 | Light intensity for a leaving ray |
| isect_diff_int_i | input | 24 | Diffuse return intensity |
| isect_refl_dir_i | input | 24 | Reflected ray direction |
| isect_refl_int_i | input | 24 | Reflected ray intensity |
| isect_trans_dir_i | input | 24 | Transmitted ray direction |
| isect_trans_int_i | input | 24 | Transmitted ray intensity |
| isect_hit_pos_i | input | 24 | Hit position, used as entry of new rays |

## Verification
A corrupted arbiter pointer shows up as returns arriving at the accumulation port in the wrong order, within one packet time of several inputs being pending together. A wrong counter or a wrong emission slot appears on the first emission of the affected packet, two cycles after it is accepted. It shows as a wrong counter field or a packet on the wrong port. A launch index or done flag that is stuck shows, right after reset, as repeated or missing home pixels in the launch stream. A hold path that moves on while stalled shows as a lost emission or a changed packet during the stall.

// File: rtl/rtmesh_pkg.sv
package rtmesh_pkg;
  parameter int AX_W  = 8;
  parameter int COL_W = 8;
  parameter int NCOL  = 3;
  parameter int PIX_W = 8;
  parameter int CTR_W = 8;
  parameter int NIN   = 6;
  parameter int NOUT  = 6;

  localparam int VEC_W = 3 * AX_W;
  localparam int INT_W = NCOL * COL_W;

  typedef enum logic [1:0] {K_RAY = 2'd0, K_RET = 2'd1, K_CLR = 2'd2} kind_e;

  typedef struct packed {
    kind_e              kind;
    logic [VEC_W-1:0]   dir;
    logic [INT_W-1:0]   inten;
    logic [PIX_W-1:0]   home_y;
    logic [PIX_W-1:0]   home_x;
    logic [VEC_W-1:0]   entry;
    logic [CTR_W-1:0]   ctr;
  } pkt_t;

  localparam int PKT_W = $bits(pkt_t);

  localparam logic [2:0] P_NORTH = 3'd0;
  localparam logic [2:0] P_EAST  = 3'd1;
  localparam logic [2:0] P_SOUTH = 3'd2;
  localparam logic [2:0] P_WEST  = 3'd3;
  localparam logic [2:0] P_SELF  = 3'd4;
  localparam logic [2:0] P_ACC   = 3'd5;
endpackage

// File: rtl/rr_arb.sv
module rr_arb #(
  parameter int N  = 6,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          take_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] gnt_idx_o
);
  logic [IW-1:0] last_q;

  always_comb begin
    logic found;
    found     = 1'b0;
    gnt_o     = '0;
    gnt_idx_o = '0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(last_q) + k) % N;
      if (!found && req_i[c]) begin
        found     = 1'b1;
        gnt_o[c]  = 1'b1;
        gnt_idx_o = IW'(c);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 last_q <= IW'(N - 1);
    else if (take_i && |req_i)   last_q <= gnt_idx_o;
  end
endmodule

// File: rtl/ret_router.sv
module ret_router
  import rtmesh_pkg::*;
#(
  parameter int NODE_X     = 1,
  parameter int NODE_Y     = 1,
  parameter int PIX_X_LOG2 = 1,
  parameter int PIX_Y_LOG2 = 1
) (
  input  logic [PIX_W-1:0] home_x_i,
  input  logic [PIX_W-1:0] home_y_i,
  output logic [2:0]       port_o
);
  localparam logic [PIX_W-1:0] NX = PIX_W'(NODE_X);
  localparam logic [PIX_W-1:0] NY = PIX_W'(NODE_Y);

  logic [PIX_W-1:0] hx, hy;
  assign hx = home_x_i >> PIX_X_LOG2;
  assign hy = home_y_i >> PIX_Y_LOG2;

  always_comb begin
    if (hx > NX)      port_o = P_EAST;
    else if (hx < NX) port_o = P_WEST;
    else if (hy > NY) port_o = P_NORTH;
    else if (hy < NY) port_o = P_SOUTH;
    else              port_o = P_ACC;
  end
endmodule

// File: rtl/emit_planner.sv
module emit_planner
  import rtmesh_pkg::*;
#(
  parameter int NODE_X     = 1,
  parameter int NODE_Y     = 1,
  parameter int PIX_X_LOG2 = 1,
  parameter int PIX_Y_LOG2 = 1
) (
  input  pkt_t             pkt_i,
  input  logic             launch_i,
  input  logic             hit_i,
  input  logic             diffuse_i,
  input  logic             specular_i,
  input  logic             transparent_i,
  input  logic [2:0]       exit_i,
  input  logic             light_i,
  input  logic [INT_W-1:0] light_int_i,
  input  logic [INT_W-1:0] diff_int_i,
  input  logic [VEC_W-1:0] refl_dir_i,
  input  logic [INT_W-1:0] refl_int_i,
  input  logic [VEC_W-1:0] trans_dir_i,
  input  logic [INT_W-1:0] trans_int_i,
  input  logic [VEC_W-1:0] hit_pos_i,
  output logic [1:0]       n_o,
  output logic [2:0]       port_o [3],
  output pkt_t             pkt_o  [3]
);
  logic [2:0] home_port;

  ret_router #(
    .NODE_X(NODE_X), .NODE_Y(NODE_Y),
    .PIX_X_LOG2(PIX_X_LOG2), .PIX_Y_LOG2(PIX_Y_LOG2)
  ) u_route (
    .home_x_i(pkt_i.home_x),
    .home_y_i(pkt_i.home_y),
    .port_o  (home_port)
  );

  function automatic pkt_t mk_ret(pkt_t src, logic [INT_W-1:0] inten, logic [CTR_W-1:0] ctr);
    pkt_t r;
    r        = '0;
    r.kind   = K_RET;
    r.inten  = inten;
    r.home_x = src.home_x;
    r.home_y = src.home_y;
    r.ctr    = ctr;
    return r;
  endfunction

  function automatic pkt_t mk_ray(pkt_t src, logic [VEC_W-1:0] dir, logic [INT_W-1:0] inten,
                                  logic [VEC_W-1:0] entry, logic [CTR_W-1:0] ctr);
    pkt_t r;
    r        = '0;
    r.kind   = K_RAY;
    r.dir    = dir;
    r.inten  = inten;
    r.home_x = src.home_x;
    r.home_y = src.home_y;
    r.entry  = entry;
    r.ctr    = ctr;
    return r;
  endfunction

  logic [1:0]       nflags;
  logic [CTR_W-1:0] ctr_one, ctr_two;

  assign nflags  = 2'(diffuse_i) + 2'(specular_i) + 2'(transparent_i);
  assign ctr_one = pkt_i.ctr + CTR_W'(nflags >= 2'd2);
  assign ctr_two = ctr_one + CTR_W'(nflags == 2'd3);

  always_comb begin
    int unsigned n;
    pkt_t        clr;
    n = 0;
    for (int i = 0; i < 3; i++) begin
      port_o[i] = P_ACC;
      pkt_o[i]  = '0;
    end
    clr        = '0;
    clr.kind   = K_CLR;
    clr.home_x = pkt_i.home_x;
    clr.home_y = pkt_i.home_y;

    if (launch_i) begin
      port_o[0] = P_ACC;
      pkt_o[0]  = clr;
      port_o[1] = P_SELF;
      pkt_o[1]  = mk_ray(pkt_i, '0, '0, '0, '0);
      n = 2;
    end else if (pkt_i.kind != K_RAY) begin
      port_o[0] = home_port;
      pkt_o[0]  = pkt_i;
      n = 1;
    end else if (!hit_i) begin
      if (exit_i >= 3'd4) begin
        port_o[0] = home_port;
        pkt_o[0]  = mk_ret(pkt_i, light_i ? light_int_i : '0, pkt_i.ctr);
      end else begin
        port_o[0] = exit_i;
        pkt_o[0]  = pkt_i;
      end
      n = 1;
    end else if (nflags == 2'd0) begin
      port_o[0] = home_port;
      pkt_o[0]  = mk_ret(pkt_i, '0, pkt_i.ctr);
      n = 1;
    end else begin
      if (diffuse_i) begin
        port_o[n] = home_port;
        pkt_o[n]  = mk_ret(pkt_i, diff_int_i, ctr_one);
        n++;
      end
      if (specular_i) begin
        port_o[n] = P_SELF;
        pkt_o[n]  = mk_ray(pkt_i, refl_dir_i, refl_int_i, hit_pos_i, ctr_two);
        n++;
      end
      if (transparent_i) begin
        port_o[n] = P_SELF;
        pkt_o[n]  = mk_ray(pkt_i, trans_dir_i, trans_int_i, hit_pos_i, ctr_two);
        n++;
      end
    end
    n_o = 2'(n);
  end
endmodule

// File: rtl/mesh_ray_dispatch.sv
module mesh_ray_dispatch
  import rtmesh_pkg::*;
#(
  parameter int NODE_X     = 1,
  parameter int NODE_Y     = 1,
  parameter int PIX_X_LOG2 = 1,
  parameter int PIX_Y_LOG2 = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NIN-1:0]        in_valid_i,
  output logic [NIN-1:0]        in_ready_o,
  input  logic [NIN*PKT_W-1:0]  in_pkt_i,
  output logic [NOUT-1:0]       out_valid_o,
  input  logic [NOUT-1:0]       out_ready_i,
  output logic [NOUT*PKT_W-1:0] out_pkt_o,
  output logic                  isect_req_o,
  output logic [PKT_W-1:0]      isect_ray_o,
  input  logic                  isect_hit_i,
  input  logic                  isect_diffuse_i,
  input  logic                  isect_specular_i,
  input  logic                  isect_transparent_i,
  input  logic [2:0]            isect_exit_i,
  input  logic                  isect_light_i,
  input  logic [INT_W-1:0]      isect_light_int_i,
  input  logic [INT_W-1:0]      isect_diff_int_i,
  input  logic [VEC_W-1:0]      isect_refl_dir_i,
  input  logic [INT_W-1:0]      isect_refl_int_i,
  input  logic [VEC_W-1:0]      isect_trans_dir_i,
  input  logic [INT_W-1:0]      isect_trans_int_i,
  input  logic [VEC_W-1:0]      isect_hit_pos_i
);
  localparam int IW    = $clog2(NIN);
  localparam int PIX_I = PIX_X_LOG2 + PIX_Y_LOG2;
  localparam logic [PIX_I-1:0] PIX_LAST = '1;

  typedef enum logic [1:0] {S_IDLE, S_PLAN, S_EMIT} state_e;

  state_e           state_q;
  pkt_t             hold_q;
  logic             launch_q;
  logic [PIX_I-1:0] pix_q;
  logic             pix_done_q;
  logic [1:0]       slot_n_q, slot_idx_q;
  logic [2:0]       slot_port_q [3];
  pkt_t             slot_pkt_q  [3];

  logic [NIN-1:0] gnt;
  logic [IW-1:0]  gnt_idx;
  logic           take;
  logic [1:0]     plan_n;
  logic [2:0]     plan_port [3];
  pkt_t           plan_pkt  [3];
  pkt_t           launch_pkt;
  pkt_t           in_sel;
  logic [2:0]     cur_port;
  pkt_t           cur_pkt;

  assign take = (state_q == S_IDLE);

  rr_arb #(.N(NIN)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (in_valid_i),
    .take_i   (take),
    .gnt_o    (gnt),
    .gnt_idx_o(gnt_idx)
  );

  assign in_ready_o = take ? gnt : '0;
  assign in_sel     = pkt_t'(in_pkt_i[gnt_idx*PKT_W +: PKT_W]);

  always_comb begin
    launch_pkt        = '0;
    launch_pkt.kind   = K_RAY;
    launch_pkt.home_x = PIX_W'(NODE_X << PIX_X_LOG2) | PIX_W'(pix_q[PIX_X_LOG2-1:0]);
    launch_pkt.home_y = PIX_W'(NODE_Y << PIX_Y_LOG2) | PIX_W'(pix_q[PIX_X_LOG2 +: PIX_Y_LOG2]);
  end

  emit_planner #(
    .NODE_X(NODE_X), .NODE_Y(NODE_Y),
    .PIX_X_LOG2(PIX_X_LOG2), .PIX_Y_LOG2(PIX_Y_LOG2)
  ) u_plan (
    .pkt_i        (hold_q),
    .launch_i     (launch_q),
    .hit_i        (isect_hit_i),
    .diffuse_i    (isect_diffuse_i),
    .specular_i   (isect_specular_i),
    .transparent_i(isect_transparent_i),
    .exit_i       (isect_exit_i),
    .light_i      (isect_light_i),
    .light_int_i  (isect_light_int_i),
    .diff_int_i   (isect_diff_int_i),
    .refl_dir_i   (isect_refl_dir_i),
    .refl_int_i   (isect_refl_int_i),
    .trans_dir_i  (isect_trans_dir_i),
    .trans_int_i  (isect_trans_int_i),
    .hit_pos_i    (isect_hit_pos_i),
    .n_o          (plan_n),
    .port_o       (plan_port),
    .pkt_o        (plan_pkt)
  );

  assign isect_req_o = (state_q == S_PLAN) && !launch_q && (hold_q.kind == K_RAY);
  assign isect_ray_o = hold_q;

  assign cur_port = slot_port_q[slot_idx_q];
  assign cur_pkt  = slot_pkt_q[slot_idx_q];

  for (genvar p = 0; p < NOUT; p++) begin : g_out
    logic sel;
    assign sel = (state_q == S_EMIT) && (cur_port == 3'(p));
    assign out_valid_o[p] = sel;
    assign out_pkt_o[p*PKT_W +: PKT_W] = sel ? cur_pkt : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      hold_q     <= '0;
      launch_q   <= 1'b0;
      pix_q      <= '0;
      pix_done_q <= 1'b0;
      slot_n_q   <= '0;
      slot_idx_q <= '0;
      for (int i = 0; i < 3; i++) begin
        slot_port_q[i] <= P_ACC;
        slot_pkt_q[i]  <= '0;
      end
    end else begin
      case (state_q)
        S_IDLE: begin
          if (|in_valid_i) begin
            hold_q   <= in_sel;
            launch_q <= 1'b0;
            state_q  <= S_PLAN;
          end else if (!pix_done_q) begin
            hold_q   <= launch_pkt;
            launch_q <= 1'b1;
            pix_q    <= pix_q + 1'b1;
            if (pix_q == PIX_LAST) pix_done_q <= 1'b1;
            state_q  <= S_PLAN;
          end
        end
        S_PLAN: begin
          slot_n_q   <= plan_n;
          slot_idx_q <= '0;
          for (int i = 0; i < 3; i++) begin
            slot_port_q[i] <= plan_port[i];
            slot_pkt_q[i]  <= plan_pkt[i];
          end
          state_q <= S_EMIT;
        end
        S_EMIT: begin
          if (out_ready_i[cur_port]) begin
            if (slot_idx_q + 2'd1 >= slot_n_q) state_q <= S_IDLE;
            else                               slot_idx_q <= slot_idx_q + 2'd1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mesh_ray_dispatch_chk.sv
module mesh_ray_dispatch_chk
  import rtmesh_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NIN-1:0]        in_valid_i,
  input logic [NIN-1:0]        in_ready_o,
  input logic [NOUT-1:0]       out_valid_o,
  input logic [NOUT-1:0]       out_ready_i,
  input logic [NOUT*PKT_W-1:0] out_pkt_o
);
  logic [1:0] acc_kind, self_kind;
  assign acc_kind  = out_pkt_o[int'(P_ACC)*PKT_W + PKT_W - 1 -: 2];
  assign self_kind = out_pkt_o[int'(P_SELF)*PKT_W + PKT_W - 1 -: 2];

  p_one_grant_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(in_ready_o));

  p_grant_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o & ~in_valid_i) == '0);

  p_one_out_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_valid_o));

  p_hold_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((out_valid_o & ~out_ready_i) != '0) |=> ($stable(out_valid_o) && $stable(out_pkt_o)));

  p_no_accept_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|out_valid_o) |-> (in_ready_o == '0));

  p_acc_no_ray_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o[P_ACC] |-> (acc_kind != 2'd0));

  p_self_ray_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o[P_SELF] |-> (self_kind == 2'd0));
endmodule

bind mesh_ray_dispatch mesh_ray_dispatch_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_pkt_o  (out_pkt_o)
);

// File: tb/mesh_ray_dispatch_test.sv
module mesh_ray_dispatch_test;
  import rtmesh_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NIN-1:0]        in_vld = '0;
  logic [NIN-1:0]        in_rdy;
  pkt_t                  in_p [NIN];
  logic [NIN*PKT_W-1:0]  in_flat;
  logic [NOUT-1:0]       out_vld;
  logic [NOUT-1:0]       out_rdy = '1;
  logic [NOUT*PKT_W-1:0] out_flat;
  logic                  isect_req;
  logic [PKT_W-1:0]      isect_ray;
  logic hit = 0, dif = 0, spc = 0, trn = 0, lgt = 0;
  logic [2:0] ext = 3'd0;
  logic [INT_W-1:0] light_int = 24'h112233, diff_int = 24'h445566;
  logic [INT_W-1:0] refl_int = 24'h778899, trans_int = 24'haabbcc;
  logic [VEC_W-1:0] refl_dir = 24'h010203, trans_dir = 24'h040506, hit_pos = 24'h0a0b0c;

  for (genvar p = 0; p < NIN; p++) begin : g_in
    assign in_flat[p*PKT_W +: PKT_W] = in_p[p];
  end

  mesh_ray_dispatch uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_vld), .in_ready_o(in_rdy), .in_pkt_i(in_flat),
    .out_valid_o(out_vld), .out_ready_i(out_rdy), .out_pkt_o(out_flat),
    .isect_req_o(isect_req), .isect_ray_o(isect_ray),
    .isect_hit_i(hit), .isect_diffuse_i(dif), .isect_specular_i(spc),
    .isect_transparent_i(trn), .isect_exit_i(ext), .isect_light_i(lgt),
    .isect_light_int_i(light_int), .isect_diff_int_i(diff_int),
    .isect_refl_dir_i(refl_dir), .isect_refl_int_i(refl_int),
    .isect_trans_dir_i(trans_dir), .isect_trans_int_i(trans_int),
    .isect_hit_pos_i(hit_pos)
  );

  int n_chk = 0, n_fail = 0;
  int   em_n = 0;
  int   em_port [32];
  pkt_t em_pkt  [32];

  function automatic pkt_t mk(logic [1:0] k, logic [23:0] d, logic [23:0] i,
                              logic [7:0] hy, logic [7:0] hx, logic [23:0] e, logic [7:0] c);
    pkt_t r;
    r = {k, d, i, hy, hx, e, c};
    return r;
  endfunction

  task automatic step();
    logic [NIN-1:0] taken;
    @(negedge clk);
    for (int p = 0; p < NOUT; p++)
      if (out_vld[p] && out_rdy[p] && em_n < 32) begin
        em_port[em_n] = p;
        em_pkt[em_n]  = pkt_t'(out_flat[p*PKT_W +: PKT_W]);
        em_n++;
      end
    taken = in_rdy & in_vld;
    @(posedge clk);
    #1 in_vld = in_vld & ~taken;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk_int(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_em(string req, int idx, int port, pkt_t exp);
    n_chk++;
    if (idx >= em_n) begin
      n_fail++;
      $display("FAIL %s emission %0d missing actual_count=%0d expected_port=%0d", req, idx, em_n, port);
    end else if (em_port[idx] != port || em_pkt[idx] != exp) begin
      n_fail++;
      $display("FAIL %s emission %0d actual port=%0d pkt=%h expected port=%0d pkt=%h",
               req, idx, em_port[idx], em_pkt[idx], port, exp);
    end
  endtask

  task automatic send(int port, pkt_t p);
    in_p[port]   = p;
    in_vld[port] = 1'b1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk_int("R1 no valid in reset", int'(out_vld), 0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_launch();
    em_n = 0;
    run(30);
    chk_int("R2 launch count", em_n, 8);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] hx, hy;
      hx = 8'(2 + (i % 2));
      hy = 8'(2 + (i / 2));
      chk_em("R2 clear", 2*i,     5, mk(2'd2, 0, 0, hy, hx, 0, 0));
      chk_em("R2 ray",   2*i + 1, 4, mk(2'd0, 0, 0, hy, hx, 0, 0));
    end
  endtask

  task automatic t_forward();
    pkt_t r;
    r = mk(2'd0, 24'h123456, 24'h654321, 8'd3, 8'd2, 24'h111111, 8'd9);
    hit = 0; ext = 3'd1; em_n = 0;
    send(0, r); run(8);
    chk_int("R3 forward count", em_n, 1);
    chk_em("R3 forward east", 0, 1, r);
    ext = 3'd3; em_n = 0;
    send(2, r); run(8);
    chk_em("R3 forward west", 0, 3, r);
  endtask

  task automatic t_leave();
    hit = 0; ext = 3'd4; lgt = 1; em_n = 0;
    send(1, mk(2'd0, 24'h1, 24'h2, 8'd3, 8'd2, 24'h3, 8'd5)); run(8);
    chk_em("R4 light return home", 0, 5, mk(2'd1, 0, light_int, 8'd3, 8'd2, 0, 8'd5));
    lgt = 0; ext = 3'd6; em_n = 0;
    send(1, mk(2'd0, 24'h1, 24'h2, 8'd2, 8'd0, 24'h3, 8'd5)); run(8);
    chk_em("R4 R5 dark return west", 0, 3, mk(2'd1, 0, 0, 8'd2, 8'd0, 0, 8'd5));
  endtask

  task automatic t_hit();
    pkt_t r;
    hit = 1;
    r = mk(2'd0, 24'h9, 24'h8, 8'd2, 8'd3, 24'h7, 8'd3);
    dif = 1; spc = 0; trn = 0; em_n = 0;
    send(1, r); run(8);
    chk_int("R6 diffuse only count", em_n, 1);
    chk_em("R6 diffuse only", 0, 5, mk(2'd1, 0, diff_int, 8'd2, 8'd3, 0, 8'd3));
    spc = 1; em_n = 0;
    send(1, r); run(10);
    chk_em("R6 diffuse of two", 0, 5, mk(2'd1, 0, diff_int, 8'd2, 8'd3, 0, 8'd4));
    chk_em("R7 R8 reflect of two", 1, 4, mk(2'd0, refl_dir, refl_int, 8'd2, 8'd3, hit_pos, 8'd4));
    r.ctr = 8'd7; trn = 1; em_n = 0;
    send(1, r); run(12);
    chk_int("R7 three count", em_n, 3);
    chk_em("R7 three return", 0, 5, mk(2'd1, 0, diff_int, 8'd2, 8'd3, 0, 8'd8));
    chk_em("R7 three reflect", 1, 4, mk(2'd0, refl_dir, refl_int, 8'd2, 8'd3, hit_pos, 8'd9));
    chk_em("R7 three transmit", 2, 4, mk(2'd0, trans_dir, trans_int, 8'd2, 8'd3, hit_pos, 8'd9));
    r.ctr = 8'd0; dif = 0; em_n = 0;
    send(1, r); run(10);
    chk_int("R7 spec trans count", em_n, 2);
    chk_em("R7 spec trans reflect", 0, 4, mk(2'd0, refl_dir, refl_int, 8'd2, 8'd3, hit_pos, 8'd1));
    chk_em("R8 spec trans transmit", 1, 4, mk(2'd0, trans_dir, trans_int, 8'd2, 8'd3, hit_pos, 8'd1));
    r.ctr = 8'd2; spc = 0; trn = 0; em_n = 0;
    send(1, r); run(8);
    chk_em("R8 no flag zero return", 0, 5, mk(2'd1, 0, 0, 8'd2, 8'd3, 0, 8'd2));
    hit = 0;
  endtask

  task automatic t_return();
    pkt_t q;
    q = mk(2'd1, 0, 24'h55, 8'd2, 8'd3, 0, 8'd4);  em_n = 0; send(5, q); run(8);
    chk_em("R5 home to acc", 0, 5, q);
    q = mk(2'd1, 0, 24'h55, 8'd0, 8'd2, 0, 8'd4);  em_n = 0; send(5, q); run(8);
    chk_em("R5 south", 0, 2, q);
    q = mk(2'd1, 0, 24'h55, 8'd6, 8'd6, 0, 8'd4);  em_n = 0; send(5, q); run(8);
    chk_em("R5 east first", 0, 1, q);
    q = mk(2'd1, 0, 24'h55, 8'd7, 8'd2, 0, 8'd4);  em_n = 0; send(5, q); run(8);
    chk_em("R5 north", 0, 0, q);
  endtask

  task automatic t_rr();
    em_n = 0;
    send(5, mk(2'd1, 0, 24'd3, 8'd2, 8'd2, 0, 0));
    send(2, mk(2'd1, 0, 24'd2, 8'd2, 8'd2, 0, 0));
    send(0, mk(2'd1, 0, 24'd1, 8'd2, 8'd2, 0, 0));
    run(20);
    chk_int("R9 rr count", em_n, 3);
    for (int i = 0; i < 3; i++)
      chk_em("R9 rr order", i, 5, mk(2'd1, 0, 24'(i + 1), 8'd2, 8'd2, 0, 0));
  endtask

  task automatic t_stall();
    pkt_t q;
    hit = 1; dif = 1; spc = 1; trn = 1; em_n = 0;
    out_rdy[4] = 1'b0;
    send(3, mk(2'd0, 24'h9, 24'h8, 8'd3, 8'd3, 24'h7, 8'd1));
    run(4);
    q = mk(2'd1, 0, 24'h77, 8'd3, 8'd3, 0, 8'd0);
    send(0, q);
    run(10);
    chk_int("R10 only first emission during stall", em_n, 1);
    chk_int("R10 input not taken during stall", int'(in_vld[0]), 1);
    out_rdy[4] = 1'b1;
    run(12);
    chk_int("R10 after release count", em_n, 4);
    chk_em("R10 reflect after release", 1, 4, mk(2'd0, refl_dir, refl_int, 8'd3, 8'd3, hit_pos, 8'd3));
    chk_em("R10 transmit after release", 2, 4, mk(2'd0, trans_dir, trans_int, 8'd3, 8'd3, hit_pos, 8'd3));
    chk_em("R10 waiting return after", 3, 5, q);
    hit = 0; dif = 0; spc = 0; trn = 0;
  endtask

  initial begin
    for (int p = 0; p < NIN; p++) in_p[p] = '0;
    t_reset();
    t_launch();
    t_forward();
    t_leave();
    t_hit();
    t_return();
    t_rr();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule